// File: doc/BRIEF.md
# Maskable Interrupt Response Controller

This block sits beside a processor core's instruction sequencer. It decides at which instruction boundary a maskable interrupt request is taken, and how the handler entry address is produced. An enable latch is set and cleared by enable and disable commands from the core. A two-bit style register selects one of three response styles:

- **Jam style.** The opcode that the device drives on the data bus is handed to the core for execution.
- **Restart style.** The return address is pushed and execution jumps to a fixed restart address.
- **Table style.** The return address is pushed first. Then two bytes are read from a handler table, and they become the new program counter. The table address is formed from a page register, which gives the high half, and the device byte, which gives the low half.

The core tells the block when it executes a halt. While halted, the core keeps issuing internal no-ops and memory refresh continues. The block leaves the halted state when it accepts an interrupt, or on reset. A return-from-interrupt indication re-opens interrupt acceptance without a separate enable command. The stack itself, table memory and the instruction pipeline are outside the block. Table memory answers a read request with data one cycle later on `tbl_rdata`.

Top module: `irq_resp_ctrl`

## Requirements
- R1: After reset the enable latch is clear (`ie_state`=0), `halted` is 0, no request output is active, and the response style is jam (code 0).
- R2: `di_cmd` clears the enable, and it wins over a simultaneous `ei_cmd` or `ret_irq`. `ei_cmd` arms the enable, but no interrupt is taken at the boundary where `ei_cmd` is asserted. The enable becomes active at the next `instr_done`, so a request can be taken at that boundary.
- R3: A request is accepted only when the block is idle, `irq_req`=1 and the enable is active, and either `instr_done`=1 or the core is halted. No acceptance happens in a cycle with `ei_cmd`, `di_cmd` or `halt_cmd`. On acceptance, `irq_ack` pulses in the following cycle and the enable is cleared.
- R4: In jam style (code 0), `exec_ext` pulses for one cycle together with `irq_ack`. `ext_opcode` carries the bus byte latched at acceptance. There is no push and no PC load.
- R5: In restart style (code 1), `push_req` with the return address and `pc_load` with `pc_new`=56 occur in the `irq_ack` cycle.
- R6: In table style (code 2), the push happens in the `irq_ack` cycle. Table reads follow in the next two cycles: first at {page_reg, bus byte with bit 0 forced to 0}, then at that address plus 1. One cycle after the second read, `pc_load` delivers `pc_new` = {byte read second, byte read first}.
- R7: `halt_cmd` (given with the halt opcode's address on `pc_cur`) sets `halted`. `halted` stays set until an interrupt is accepted or reset. While the enable is clear, requests do not end the halted state.
- R8: When the core is halted, the interrupt is accepted without waiting for `instr_done`. `halt_exit` pulses with `irq_ack`, and the pushed return address is the halt address plus 1.
- R9: `ret_irq` sets the enable. A request present at that same boundary is accepted immediately.
- R10: `mode_wr` loads `mode_sel` into the style register. Code 3 is ignored and the previous style stays in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Maskable interrupt request level |
| instr_done | input | 1 | An instruction completes this cycle |
| ei_cmd | input | 1 | Enable command completes this cycle |
| di_cmd | input | 1 | Disable command completes this cycle |
| ret_irq | input | 1 | Return-from-interrupt completes this cycle |
| halt_cmd | input | 1 | Halt instruction reached; `pc_cur` holds its address |
| mode_wr | input | 1 | Write strobe for the style register |
| mode_sel | input | 2 | New style code (0 jam, 1 restart, 2 table) |
| bus_byte | input | 8 | Byte the interrupting device drives |
| page_reg | input | 8 | Handler table page (high address half) |
| pc_cur | input | 16 | Address of the next instruction at a boundary |
| tbl_rdata | input | 8 | Table read data, one cycle after the request |
| irq_ack | output | 1 | Interrupt accepted, first response cycle |
| ie_state | output | 1 | Enable latch state |
| halted | output | 1 | Core idles on internal no-ops |
| halt_exit | output | 1 | Halted state ends for this interrupt |
| exec_ext | output | 1 | Execute `ext_opcode` supplied by the device |
| ext_opcode | output | 8 | Latched device opcode |
| push_req | output | 1 | Push `push_data` onto the downward stack |
| push_data | output | 16 | Return address to push |
| tbl_rd_req | output | 1 | Handler table read request |
| tbl_addr | output | 16 | Handler table byte address |
| pc_load | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | 16 | Handler entry address |

## Verification
A return-from-interrupt and a new request can arrive at the same instruction boundary. In that case the request must be taken at once, even though the enable was clear before that edge. The bench provokes this by holding `irq_req` high with the enable clear and pulsing `ret_irq` together with `instr_done`. It then expects the jam response in the very next cycle and the enable cleared again afterwards. A second overlap is an enable or disable command coinciding with a boundary that has a request pending. The bench judges this by the absence of any response event, and by the `ie_state` read back a cycle later.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;

   typedef enum logic [1:0] {
      IM_JAM = 2'd0,
      IM_RST = 2'd1,
      IM_TBL = 2'd2
   } irq_mode_e;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_ENTRY = 3'd1,
      SQ_RDLO  = 3'd2,
      SQ_RDHI  = 3'd3,
      SQ_LOAD  = 3'd4
   } seq_st_e;

endpackage

// File: rtl/irq_enable_latch.sv
module irq_enable_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic ei_cmd,
   input  logic di_cmd,
   input  logic ret_irq,
   input  logic instr_done,
   input  logic accept,
   output logic ie_q,
   output logic ie_eff
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         pend_q <= 1'b0;
      end else if (di_cmd || accept) begin
         ie_q   <= 1'b0;
         pend_q <= 1'b0;
      end else if (ret_irq) begin
         ie_q   <= 1'b1;
         pend_q <= 1'b0;
      end else if (ei_cmd) begin
         pend_q <= 1'b1;
      end else if (pend_q && instr_done) begin
         ie_q   <= 1'b1;
         pend_q <= 1'b0;
      end
   end

   // Effective enable seen by the acceptance decision this cycle.
   assign ie_eff = ie_q | pend_q | ret_irq;
endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg
   import irq_resp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_wr,
   input  logic [1:0] mode_sel,
   output irq_mode_e  mode_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= IM_JAM;
      else if (mode_wr && (mode_sel != 2'b11))
         mode_q <= irq_mode_e'(mode_sel);
   end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_resp_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] RST_VEC   = 16'd56,
   parameter bit                ALIGN_VEC = 1'b1,
   localparam int               PAGE_W    = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic              instr_done,
   input  logic              halt_cmd,
   input  logic              ei_cmd,
   input  logic              di_cmd,
   input  logic              ie_eff,
   input  irq_mode_e         mode,
   input  logic [DATA_W-1:0] bus_byte,
   input  logic [PAGE_W-1:0] page_reg,
   input  logic [ADDR_W-1:0] pc_cur,
   input  logic [DATA_W-1:0] tbl_rdata,
   output logic              accept,
   output logic              irq_ack,
   output logic              halt_exit,
   output logic              halted,
   output logic              exec_ext,
   output logic [DATA_W-1:0] ext_opcode,
   output logic              push_req,
   output logic [ADDR_W-1:0] push_data,
   output logic              tbl_rd_req,
   output logic [ADDR_W-1:0] tbl_addr,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_new
);
   seq_st_e           st_q;
   irq_mode_e         m_q;
   logic              was_halt_q;
   logic [ADDR_W-1:0] ret_q;
   logic [ADDR_W-1:0] halt_pc_q;
   logic [ADDR_W-1:0] vec_q;
   logic [DATA_W-1:0] byte_q;
   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] vec_low;

   // Variant: entries on two-byte boundaries or byte-granular table.
   if (ALIGN_VEC) begin : g_align
      assign vec_low = {bus_byte[DATA_W-1:1], 1'b0};
   end else begin : g_raw
      assign vec_low = bus_byte;
   end

   assign accept = (st_q == SQ_IDLE) && irq_req && ie_eff &&
                   !ei_cmd && !di_cmd && !halt_cmd &&
                   (instr_done || halted);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         m_q        <= IM_JAM;
         halted     <= 1'b0;
         was_halt_q <= 1'b0;
         ret_q      <= '0;
         halt_pc_q  <= '0;
         vec_q      <= '0;
         byte_q     <= '0;
         lo_q       <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: begin
               if (accept) begin
                  st_q       <= SQ_ENTRY;
                  m_q        <= mode;
                  was_halt_q <= halted;
                  halted     <= 1'b0;
                  ret_q      <= halted ? ADDR_W'(halt_pc_q + 1'b1) : pc_cur;
                  byte_q     <= bus_byte;
                  vec_q      <= {page_reg, vec_low};
               end else if (halt_cmd) begin
                  halted    <= 1'b1;
                  halt_pc_q <= pc_cur;
               end
            end
            SQ_ENTRY: st_q <= (m_q == IM_TBL) ? SQ_RDLO : SQ_IDLE;
            SQ_RDLO:  st_q <= SQ_RDHI;
            SQ_RDHI: begin
               lo_q <= tbl_rdata;
               st_q <= SQ_LOAD;
            end
            SQ_LOAD:  st_q <= SQ_IDLE;
            default:  st_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      irq_ack    = (st_q == SQ_ENTRY);
      halt_exit  = irq_ack && was_halt_q;
      exec_ext   = irq_ack && (m_q == IM_JAM);
      ext_opcode = byte_q;
      push_req   = irq_ack && (m_q != IM_JAM);
      push_data  = ret_q;
      tbl_rd_req = (st_q == SQ_RDLO) || (st_q == SQ_RDHI);
      tbl_addr   = (st_q == SQ_RDHI) ? ADDR_W'(vec_q + 1'b1) : vec_q;
      pc_load    = (irq_ack && (m_q == IM_RST)) || (st_q == SQ_LOAD);
      pc_new     = (st_q == SQ_LOAD) ? {tbl_rdata, lo_q} : RST_VEC;
   end
endmodule

// File: rtl/irq_resp_ctrl.sv
module irq_resp_ctrl
   import irq_resp_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] RST_VEC   = 16'd56,
   parameter bit                ALIGN_VEC = 1'b1,
   localparam int               PAGE_W    = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic              instr_done,
   input  logic              ei_cmd,
   input  logic              di_cmd,
   input  logic              ret_irq,
   input  logic              halt_cmd,
   input  logic              mode_wr,
   input  logic [1:0]        mode_sel,
   input  logic [DATA_W-1:0] bus_byte,
   input  logic [PAGE_W-1:0] page_reg,
   input  logic [ADDR_W-1:0] pc_cur,
   input  logic [DATA_W-1:0] tbl_rdata,
   output logic              irq_ack,
   output logic              ie_state,
   output logic              halted,
   output logic              halt_exit,
   output logic              exec_ext,
   output logic [DATA_W-1:0] ext_opcode,
   output logic              push_req,
   output logic [ADDR_W-1:0] push_data,
   output logic              tbl_rd_req,
   output logic [ADDR_W-1:0] tbl_addr,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_new
);
   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("irq_resp_ctrl: ADDR_W must be twice DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("irq_resp_ctrl: DATA_W must be at least 2");
   end

   logic      ie_eff;
   logic      accept;
   irq_mode_e mode;

   irq_enable_latch u_en (
      .clk        (clk),
      .rst_n      (rst_n),
      .ei_cmd     (ei_cmd),
      .di_cmd     (di_cmd),
      .ret_irq    (ret_irq),
      .instr_done (instr_done),
      .accept     (accept),
      .ie_q       (ie_state),
      .ie_eff     (ie_eff)
   );

   irq_mode_reg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_wr  (mode_wr),
      .mode_sel (mode_sel),
      .mode_q   (mode)
   );

   irq_seq #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .RST_VEC   (RST_VEC),
      .ALIGN_VEC (ALIGN_VEC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_req    (irq_req),
      .instr_done (instr_done),
      .halt_cmd   (halt_cmd),
      .ei_cmd     (ei_cmd),
      .di_cmd     (di_cmd),
      .ie_eff     (ie_eff),
      .mode       (mode),
      .bus_byte   (bus_byte),
      .page_reg   (page_reg),
      .pc_cur     (pc_cur),
      .tbl_rdata  (tbl_rdata),
      .accept     (accept),
      .irq_ack    (irq_ack),
      .halt_exit  (halt_exit),
      .halted     (halted),
      .exec_ext   (exec_ext),
      .ext_opcode (ext_opcode),
      .push_req   (push_req),
      .push_data  (push_data),
      .tbl_rd_req (tbl_rd_req),
      .tbl_addr   (tbl_addr),
      .pc_load    (pc_load),
      .pc_new     (pc_new)
   );
endmodule

// File: rtl/irq_resp_chk.sv
module irq_resp_chk #(
   parameter int                ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] RST_VEC = 16'd56
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_req,
   input logic              di_cmd,
   input logic              ret_irq,
   input logic              irq_ack,
   input logic              ie_state,
   input logic              halted,
   input logic              halt_exit,
   input logic              exec_ext,
   input logic              push_req,
   input logic              tbl_rd_req,
   input logic [ADDR_W-1:0] tbl_addr,
   input logic              pc_load,
   input logic [ADDR_W-1:0] pc_new
);
   // R2
   di_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      di_cmd |=> !ie_state);

   // R3
   ack_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> !ie_state);

   // R4
   jam_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_ext |-> (!push_req && !pc_load));

   // R5
   restart_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && push_req) |-> (pc_new == RST_VEC));

   // R6
   push_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tbl_rd_req) |-> $past(push_req));

   // R6
   second_read_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_rd_req && $past(tbl_rd_req)) |-> (tbl_addr == ADDR_W'($past(tbl_addr) + 1'b1)));

   // R6
   one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({exec_ext, tbl_rd_req, pc_load}));

   // R8
   exit_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_exit |-> (irq_ack && !halted));

   // R9
   ret_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_irq && !di_cmd && !irq_req) |=> ie_state);
endmodule

bind irq_resp_ctrl irq_resp_chk #(
   .ADDR_W  (ADDR_W),
   .RST_VEC (RST_VEC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_req    (irq_req),
   .di_cmd     (di_cmd),
   .ret_irq    (ret_irq),
   .irq_ack    (irq_ack),
   .ie_state   (ie_state),
   .halted     (halted),
   .halt_exit  (halt_exit),
   .exec_ext   (exec_ext),
   .push_req   (push_req),
   .tbl_rd_req (tbl_rd_req),
   .tbl_addr   (tbl_addr),
   .pc_load    (pc_load),
   .pc_new     (pc_new)
);

// File: tb/irq_resp_ctrl_bench.sv
module irq_resp_ctrl_bench;
   localparam int CLK_P = 10;
   localparam int EV_HX = 0, EV_EXT = 1, EV_PUSH = 2, EV_RD = 3, EV_PC = 4;

   typedef struct {
      int          kind;
      logic [15:0] val;
      string       tag;
   } ev_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 0, instr_done = 0, ei_cmd = 0, di_cmd = 0;
   logic        ret_irq = 0, halt_cmd = 0, mode_wr = 0;
   logic [1:0]  mode_sel = 0;
   logic [7:0]  bus_byte = 0, page_reg = 0, tbl_rdata = 0;
   logic [15:0] pc_cur = 0;
   logic        irq_ack, ie_state, halted, halt_exit, exec_ext;
   logic        push_req, tbl_rd_req, pc_load;
   logic [7:0]  ext_opcode;
   logic [15:0] push_data, tbl_addr, pc_new;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 0;
   ev_t  q[$];

   always #(CLK_P/2) clk = ~clk;

   irq_resp_ctrl u_irq_resp_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_done(instr_done),
      .ei_cmd(ei_cmd), .di_cmd(di_cmd), .ret_irq(ret_irq), .halt_cmd(halt_cmd),
      .mode_wr(mode_wr), .mode_sel(mode_sel), .bus_byte(bus_byte),
      .page_reg(page_reg), .pc_cur(pc_cur), .tbl_rdata(tbl_rdata),
      .irq_ack(irq_ack), .ie_state(ie_state), .halted(halted),
      .halt_exit(halt_exit), .exec_ext(exec_ext), .ext_opcode(ext_opcode),
      .push_req(push_req), .push_data(push_data), .tbl_rd_req(tbl_rd_req),
      .tbl_addr(tbl_addr), .pc_load(pc_load), .pc_new(pc_new)
   );

   function automatic logic [7:0] tbl_byte(input logic [15:0] a);
      return (a[7:0] + 8'h3C) ^ a[15:8];
   endfunction

   // Table memory model: data one cycle after the request.
   always @(posedge clk) tbl_rdata <= tbl_byte(tbl_addr);

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic expect_ev(input int kind, input logic [15:0] val, input string tag);
      ev_t e;
      e.kind = kind; e.val = val; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic mon_one(input int kind, input logic [15:0] val);
      ev_t e;
      if (q.size() == 0) begin
         chk(1'b0, "R3 unexpected response event", 16'(kind), 16'hFFFF);
      end else begin
         e = q.pop_front();
         chk(e.kind == kind && e.val == val, e.tag, val, e.val);
      end
   endtask

   // Monitor: outputs are register-derived, sampled at the falling edge.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (halt_exit)  mon_one(EV_HX, 16'h0);
            if (exec_ext)   mon_one(EV_EXT, {8'h0, ext_opcode});
            if (push_req)   mon_one(EV_PUSH, push_data);
            if (tbl_rd_req) mon_one(EV_RD, tbl_addr);
            if (pc_load)    mon_one(EV_PC, pc_new);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bnd(input bit ei, input bit di, input bit ret, input bit hlt);
      @(negedge clk);
      instr_done = 1; ei_cmd = ei; di_cmd = di; ret_irq = ret; halt_cmd = hlt;
      @(negedge clk);
      instr_done = 0; ei_cmd = 0; di_cmd = 0; ret_irq = 0; halt_cmd = 0;
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      mode_wr = 1; mode_sel = m;
      @(negedge clk);
      mode_wr = 0;
   endtask

   task automatic drain(input string tag);
      tick(6);
      chk(q.size() == 0, tag, 16'(q.size()), 16'h0);
      q.delete();
   endtask

   initial begin
      tick(3);
      // R1 reset state
      chk(ie_state == 0, "R1 enable after reset", 16'(ie_state), 16'h0);
      chk(halted == 0, "R1 halted after reset", 16'(halted), 16'h0);
      chk(!(irq_ack | push_req | pc_load | tbl_rd_req | exec_ext), "R1 outputs idle in reset",
          16'(irq_ack | push_req | pc_load), 16'h0);
      rst_n = 1;
      tick(2);

      // R3 request with enable clear is ignored
      irq_req = 1; bus_byte = 8'hC3;
      bnd(0, 0, 0, 0);
      drain("R3 no response while disabled");

      // R2 enable delayed past the following instruction; default style jam R1/R4
      bnd(1, 0, 0, 0);
      chk(ie_state == 0, "R2 enable not yet active", 16'(ie_state), 16'h0);
      tick(3);
      expect_ev(EV_EXT, 16'h00C3, "R4 jam opcode (default style R1)");
      bnd(0, 0, 0, 0);
      irq_req = 0;
      chk(ie_state == 0, "R3 acceptance clears enable", 16'(ie_state), 16'h0);
      drain("R4 jam events complete");

      // R3 no boundary no acceptance
      bnd(1, 0, 0, 0); bnd(0, 0, 0, 0);
      chk(ie_state == 1, "R2 enable active after following instruction", 16'(ie_state), 16'h1);
      irq_req = 1; bus_byte = 8'h5A;
      tick(4);
      chk(q.size() == 0, "R3 waits for boundary", 16'(q.size()), 16'h0);
      expect_ev(EV_EXT, 16'h005A, "R3 taken at boundary");
      bnd(0, 0, 0, 0);
      irq_req = 0;
      drain("R3 boundary events complete");

      // R5 restart style
      set_mode(2'd1);
      bnd(1, 0, 0, 0); bnd(0, 0, 0, 0);
      pc_cur = 16'h1234; irq_req = 1;
      expect_ev(EV_PUSH, 16'h1234, "R5 push return address");
      expect_ev(EV_PC, 16'd56, "R5 restart address");
      bnd(0, 0, 0, 0);
      irq_req = 0;
      drain("R5 restart events complete");

      // R6 table style, odd device byte forced even
      set_mode(2'd2);
      bnd(1, 0, 0, 0); bnd(0, 0, 0, 0);
      pc_cur = 16'h4567; page_reg = 8'h80; bus_byte = 8'h13; irq_req = 1;
      expect_ev(EV_PUSH, 16'h4567, "R6 push first");
      expect_ev(EV_RD, 16'h8012, "R6 low byte address");
      expect_ev(EV_RD, 16'h8013, "R6 high byte address");
      expect_ev(EV_PC, {tbl_byte(16'h8013), tbl_byte(16'h8012)}, "R6 loaded handler");
      bnd(0, 0, 0, 0);
      irq_req = 0; bus_byte = 8'h00;
      drain("R6 table events complete");

      // R10 code 3 ignored
      set_mode(2'd1);
      set_mode(2'd3);
      bnd(1, 0, 0, 0); bnd(0, 0, 0, 0);
      pc_cur = 16'h0ABC; irq_req = 1;
      expect_ev(EV_PUSH, 16'h0ABC, "R10 style kept push");
      expect_ev(EV_PC, 16'd56, "R10 style kept restart");
      bnd(0, 0, 0, 0);
      irq_req = 0;
      drain("R10 events complete");

      // R7/R8 halt with enable set, exit on request
      bnd(1, 0, 0, 0);
      pc_cur = 16'h0200;
      bnd(0, 0, 0, 1);
      chk(halted == 1, "R7 halted set", 16'(halted), 16'h1);
      pc_cur = 16'h7777;
      tick(3);
      chk(halted == 1, "R7 halted holds", 16'(halted), 16'h1);
      expect_ev(EV_HX, 16'h0, "R8 halt exit");
      expect_ev(EV_PUSH, 16'h0201, "R8 push address after halt");
      expect_ev(EV_PC, 16'd56, "R8 restart after halt");
      @(negedge clk); irq_req = 1;
      tick(2); irq_req = 0;
      drain("R8 halt events complete");
      chk(halted == 0, "R8 halted cleared", 16'(halted), 16'h0);

      // R7 halt with enable clear: request ignored, reset ends it
      pc_cur = 16'h0300;
      bnd(0, 0, 0, 1);
      irq_req = 1;
      tick(5);
      chk(halted == 1, "R7 disabled request keeps halt", 16'(halted), 16'h1);
      drain("R7 no response while halted and disabled");
      irq_req = 0;
      @(negedge clk); rst_n = 0;
      tick(2); rst_n = 1;
      tick(1);
      chk(halted == 0, "R7 reset ends halt", 16'(halted), 16'h0);
      chk(ie_state == 0, "R1 enable after second reset", 16'(ie_state), 16'h0);

      // R9 return and request at same boundary, style back to jam (R1)
      irq_req = 1; bus_byte = 8'hC7;
      expect_ev(EV_EXT, 16'h00C7, "R9 taken at return boundary");
      bnd(0, 0, 1, 0);
      irq_req = 0;
      chk(ie_state == 0, "R9 enable cleared by acceptance", 16'(ie_state), 16'h0);
      drain("R9 events complete");
      bnd(0, 0, 1, 0);
      chk(ie_state == 1, "R9 return sets enable", 16'(ie_state), 16'h1);

      // R2 disable with pending request
      irq_req = 1;
      bnd(0, 1, 0, 0);
      chk(ie_state == 0, "R2 disable clears", 16'(ie_state), 16'h0);
      drain("R2 no response after disable");
      irq_req = 0;

      // R2 disable wins over enable
      bnd(1, 1, 0, 0); bnd(0, 0, 0, 0);
      chk(ie_state == 0, "R2 disable wins", 16'(ie_state), 16'h0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog R3 actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule